// File: doc/BRIEF.md
# Next-PC Sequencing Unit

This block owns the 32-bit program counter of a simple fetch stage and picks, every clock cycle, the address of the next instruction to fetch. It looks at the instruction word that is being fetched now. It also looks at the two register operands read for an equality compare, and at one register value used as an indirect jump target. From these it chooses between straight-line flow, a PC-relative conditional branch, a region-relative direct jump, a call that also asks for a link register write, and a register-indirect jump.

The block drives the current PC and the incremented PC. For calls it also drives a register-file write request: a write enable, the register index and the return address. A stall input freezes the counter and blocks the link write for that cycle. A synchronous reset loads a start address that is set by a parameter.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` is loaded with the parameter `RESET_ADDR` (default 0x0040_0000), and `link_we` is 0 while `rst` is high.
- R2: `pc_plus4` always equals `pc_q + 4`. An instruction that is not a branch or jump, with `stall` low, makes the next `pc_q` equal `pc_q + 4`.
- R3: Opcode `instr[31:26]` = 0x04 is branch-if-equal. When `cmp_a == cmp_b` the next PC is `pc_q + 4 + (sign-extended instr[15:0] << 2)`; otherwise it is `pc_q + 4`.
- R4: Opcode 0x05 is branch-if-different. It uses the same target as R3, but it is taken only when `cmp_a != cmp_b`; otherwise the next PC is `pc_q + 4`.
- R5: Opcode 0x02 is a direct jump. The next PC is `{(pc_q+4)[31:28], instr[25:0], 2'b00}`.
- R6: Opcode 0x03 is a call. It jumps like R5, and in the same cycle it drives `link_we` = 1, `link_idx` = 31 and `link_data` = `pc_q + 4`. For any other instruction, `link_we` is 0.
- R7: Opcode 0x00 with function field `instr[5:0]` = 0x08 is a register jump: the next PC is `jr_val`. Opcode 0x00 with any other function field gives sequential flow.
- R8: While `stall` is high, `pc_q` keeps its value at the clock edge and `link_we` is 0, whatever the instruction is.
- R9: Branch offsets are signed. Offset 0xFFFD moves the target three instructions back from `pc_q + 4`, and offset 0x8000 is the most negative reach (−131072 bytes).
- R10: The jump region comes from `pc_q + 4`, not from `pc_q`. A jump at 0x0FFF_FFFC lands in region 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold PC and suppress the link write |
| instr | input | 32 | Instruction word being fetched this cycle |
| cmp_a | input | 32 | First register operand for the branch compare |
| cmp_b | input | 32 | Second register operand for the branch compare |
| jr_val | input | 32 | Register value used by the register jump |
| pc_q | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus 4 |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index (31) |
| link_data | output | 32 | Return address written on a call |

## Verification
Two functions can fall in the same cycle. A call both redirects the PC and requests a link write, and a stall can arrive together with a call or with a taken branch. The bench issues calls with `stall` low and with `stall` high. It checks the link outputs in the cycle the call is presented, and it checks that the counter either jumps or holds at the next edge. A jump placed at the last word of a 256 MB region checks that the region bits follow the incremented PC at the moment it wraps into the next region.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  localparam logic [5:0] OPC_REGOP  = 6'h00;
  localparam logic [5:0] OPC_GOTO   = 6'h02;
  localparam logic [5:0] OPC_CALL   = 6'h03;
  localparam logic [5:0] OPC_BR_EQ  = 6'h04;
  localparam logic [5:0] OPC_BR_NE  = 6'h05;
  localparam logic [5:0] FN_REGJUMP = 6'h08;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BR_EQ,
    FLOW_BR_NE,
    FLOW_GOTO,
    FLOW_CALL,
    FLOW_REGJUMP
  } flow_e;

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output flow_e        kind,
  output logic         br_taken
);

  logic same;
  assign same = (opnd_a == opnd_b);

  always_comb begin
    case (opcode)
      OPC_BR_EQ: kind = FLOW_BR_EQ;
      OPC_BR_NE: kind = FLOW_BR_NE;
      OPC_GOTO:  kind = FLOW_GOTO;
      OPC_CALL:  kind = FLOW_CALL;
      OPC_REGOP: kind = (funct == FN_REGJUMP) ? FLOW_REGJUMP : FLOW_SEQ;
      default:   kind = FLOW_SEQ;
    endcase
  end

  always_comb begin
    case (kind)
      FLOW_BR_EQ: br_taken = same;
      FLOW_BR_NE: br_taken = !same;
      default:    br_taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target #(
  parameter int unsigned W     = 32,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned IDX_W = 26
) (
  input  logic [W-1:0]     pc,
  input  logic [OFF_W-1:0] offset,
  input  logic [IDX_W-1:0] index,
  output logic [W-1:0]     pc_inc,
  output logic [W-1:0]     br_tgt,
  output logic [W-1:0]     jmp_tgt
);

  localparam int unsigned EXT_W    = W - OFF_W - 2;
  localparam int unsigned REGION_W = W - IDX_W - 2;

  function automatic logic [W-1:0] step_word(input logic [W-1:0] a);
    return a + W'(4);
  endfunction

  function automatic logic [W-1:0] rel_target(input logic [W-1:0] base,
                                              input logic [OFF_W-1:0] off);
    logic [W-1:0] disp;
    disp = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    return base + disp;
  endfunction

  function automatic logic [W-1:0] region_target(input logic [W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    return {base[W-1 -: REGION_W], idx, 2'b00};
  endfunction

  assign pc_inc  = step_word(pc);
  assign br_tgt  = rel_target(pc_inc, offset);
  assign jmp_tgt = region_target(pc_inc, index);

endmodule

// File: rtl/pcseq_pcreg.sv
module pcseq_pcreg #(
  parameter int unsigned W          = 32,
  parameter logic [W-1:0] RESET_ADDR = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_ADDR;
    else if (!hold) q <= d;
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int unsigned  W          = 32,
  parameter int unsigned  RIDX_W     = 5,
  parameter int unsigned  LINK_REG   = 31,
  parameter logic [W-1:0] RESET_ADDR = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic [W-1:0]      instr,
  input  logic [W-1:0]      cmp_a,
  input  logic [W-1:0]      cmp_b,
  input  logic [W-1:0]      jr_val,
  output logic [W-1:0]      pc_q,
  output logic [W-1:0]      pc_plus4,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [W-1:0]      link_data
);

  localparam int unsigned OFF_W = 16;
  localparam int unsigned IDX_W = 26;

  flow_e        kind;
  logic         br_taken;
  logic         ev_call;
  logic         ev_goto;
  logic         ev_regjump;
  logic [W-1:0] br_tgt;
  logic [W-1:0] jmp_tgt;
  logic [W-1:0] pc_next;

  pcseq_decode #(.W(W)) dec_i (
    .opcode   (instr[W-1 -: 6]),
    .funct    (instr[5:0]),
    .opnd_a   (cmp_a),
    .opnd_b   (cmp_b),
    .kind     (kind),
    .br_taken (br_taken)
  );

  pcseq_target #(.W(W), .OFF_W(OFF_W), .IDX_W(IDX_W)) tgt_i (
    .pc      (pc_q),
    .offset  (instr[OFF_W-1:0]),
    .index   (instr[IDX_W-1:0]),
    .pc_inc  (pc_plus4),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt)
  );

  assign ev_call    = (kind == FLOW_CALL);
  assign ev_goto    = (kind == FLOW_GOTO);
  assign ev_regjump = (kind == FLOW_REGJUMP);

  always_comb begin
    if (br_taken)                pc_next = br_tgt;
    else if (ev_goto || ev_call) pc_next = jmp_tgt;
    else if (ev_regjump)         pc_next = jr_val;
    else                         pc_next = pc_plus4;
  end

  pcseq_pcreg #(.W(W), .RESET_ADDR(RESET_ADDR)) reg_i (
    .clk  (clk),
    .rst  (rst),
    .hold (stall),
    .d    (pc_next),
    .q    (pc_q)
  );

  assign link_we   = ev_call && !stall && !rst;
  assign link_idx  = RIDX_W'(LINK_REG);
  assign link_data = pc_plus4;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int unsigned  W          = 32,
  parameter logic [W-1:0] RESET_ADDR = 32'h0040_0000
) (
  input logic         clk,
  input logic         rst,
  input logic         stall,
  input logic [W-1:0] instr,
  input logic [W-1:0] jr_val,
  input logic [W-1:0] pc_q,
  input logic [W-1:0] pc_plus4,
  input logic         link_we,
  input logic         br_taken,
  input logic         ev_call,
  input logic         ev_goto,
  input logic         ev_regjump
);

  AST_RESET_LOAD: assert property (@(posedge clk) rst |=> pc_q == RESET_ADDR); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> pc_q == $past(pc_q)); // R8

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!stall && !br_taken && !ev_call && !ev_goto && !ev_regjump)
      |=> pc_q == $past(pc_plus4)); // R2

  AST_REGJUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!stall && ev_regjump) |=> pc_q == $past(jr_val)); // R7

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (!stall && (ev_goto || ev_call))
      |=> pc_q[W-1 -: 4] == $past(pc_plus4[W-1 -: 4])); // R5

  AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (instr[W-1 -: 6] == 6'h03) && !stall); // R6

  AST_BRANCH_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_taken) |=> pc_q[1:0] == $past(pc_plus4[1:0])); // R3

endmodule

bind pc_sequencer pcseq_chk #(.W(W), .RESET_ADDR(RESET_ADDR)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .stall      (stall),
  .instr      (instr),
  .jr_val     (jr_val),
  .pc_q       (pc_q),
  .pc_plus4   (pc_plus4),
  .link_we    (link_we),
  .br_taken   (br_taken),
  .ev_call    (ev_call),
  .ev_goto    (ev_goto),
  .ev_regjump (ev_regjump)
);

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb_top;

  localparam logic [31:0] START = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] cmp_a = 32'h0;
  logic [31:0] cmp_b = 32'h0;
  logic [31:0] jr_val = 32'h0;
  logic [31:0] pc_q, pc_plus4, link_data;
  logic        link_we;
  logic [4:0]  link_idx;

  int total = 0;
  int fails = 0;
  logic [31:0] exp_pc;

  always #2.5 clk = ~clk;

  pc_sequencer dut_i (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .jr_val(jr_val),
    .pc_q(pc_q), .pc_plus4(pc_plus4), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data)
  );

  function automatic logic [31:0] mk_imm(input logic [5:0] op, input logic [15:0] off);
    return {op, 5'd3, 5'd7, off};
  endfunction

  function automatic logic [31:0] mk_far(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction

  function automatic logic [31:0] mk_reg(input logic [5:0] fn);
    return {6'h00, 5'd9, 5'd0, 5'd0, 5'd0, fn};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one instruction at a falling edge, check combinational outputs,
  // then check the PC after the following rising edge.
  task automatic issue(input string req, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] r, input logic stl);
    logic [31:0] nxt;
    logic [31:0] inc;
    logic [5:0]  op;
    int          disp;
    instr = ins; cmp_a = a; cmp_b = b; jr_val = r; stall = stl;
    #1;
    op  = ins[31:26];
    inc = exp_pc + 32'd4;
    check({req, " pc_plus4 (R2)"}, pc_plus4, inc);
    check({req, " link_we (R6/R8)"}, {31'd0, link_we}, {31'd0, (op == 6'h03) && !stl});
    if (op == 6'h03 && !stl) begin
      check({req, " link_idx (R6)"}, {27'd0, link_idx}, 32'd31);
      check({req, " link_data (R6)"}, link_data, inc);
    end
    disp = 32'($signed(ins[15:0])) * 4;
    if ((op == 6'h04 && a == b) || (op == 6'h05 && a != b)) nxt = inc + 32'(disp);
    else if (op == 6'h02 || op == 6'h03) nxt = (inc & 32'hF000_0000) | (32'(ins[25:0]) * 4);
    else if (op == 6'h00 && ins[5:0] == 6'h08) nxt = r;
    else nxt = inc;
    if (stl) nxt = exp_pc;
    @(negedge clk);
    exp_pc = nxt;
    check({req, " next pc"}, pc_q, exp_pc);
    stall = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset pc", pc_q, START);
    check("R1 link_we in reset", {31'd0, link_we}, 32'd0);
    exp_pc = START;

    // R2 sequential flow, several non-flow opcodes and regop functions (R7)
    issue("R2 seq op08", mk_imm(6'h08, 16'h1234), 0, 0, 0, 0);
    issue("R2 seq op23", mk_imm(6'h23, 16'hFFFF), 0, 0, 0, 0);
    for (int f = 0; f < 64; f += 7) issue("R7 regop other funct", mk_reg(6'(f == 8 ? 9 : f)), 0, 0, 32'h1111_0000, 0);
    issue("R7 regop funct08", mk_reg(6'h08), 0, 0, 32'h0100_0000, 0);

    // R3/R4 sweep of offsets and operand relations
    for (int k = 0; k < 8; k++) begin
      logic [15:0] off;
      off = 16'(k * 16'h2345);
      issue("R3 beq equal", mk_imm(6'h04, off), 32'hA5A5_0000 + k, 32'hA5A5_0000 + k, 0, 0);
      issue("R3 beq differ", mk_imm(6'h04, off), 32'h5, 32'h5 ^ (32'h1 << k), 0, 0);
      issue("R4 bne differ", mk_imm(6'h05, off), 32'h1 << k, 32'h0, 0, 0);
      issue("R4 bne equal", mk_imm(6'h05, off), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    end

    // R9 offset boundaries
    issue("R7 set pc", mk_reg(6'h08), 0, 0, 32'h0200_0000, 0);
    issue("R9 back three", mk_imm(6'h04, 16'hFFFD), 1, 1, 0, 0);
    check("R9 back three absolute", pc_q, 32'h0200_0004 - 32'd12);
    issue("R9 most negative", mk_imm(6'h05, 16'h8000), 1, 2, 0, 0);
    issue("R9 most positive", mk_imm(6'h04, 16'h7FFF), 3, 3, 0, 0);

    // R5/R6 jumps and calls
    for (int k = 0; k < 6; k++) begin
      issue("R5 jump", mk_far(6'h02, 26'(32'h0155_5555 >> k)), 0, 0, 0, 0);
      issue("R6 call", mk_far(6'h03, 26'(32'h02AA_AAAA >> k)), 0, 0, 0, 0);
    end

    // R10 region wrap taken from pc+4
    issue("R7 set pc edge", mk_reg(6'h08), 0, 0, 32'h0FFF_FFFC, 0);
    issue("R10 jump at region edge", mk_far(6'h02, 26'h000_0040), 0, 0, 0, 0);
    check("R10 region 1", pc_q, 32'h1000_0100);
    issue("R7 set pc edge2", mk_reg(6'h08), 0, 0, 32'h0FFF_FFFC, 0);
    issue("R10 call at region edge", mk_far(6'h03, 26'h3FF_FFFF), 0, 0, 0, 0);

    // R8 stall against each flow kind, including call with stall
    issue("R8 stall call", mk_far(6'h03, 26'h123), 0, 0, 0, 1);
    issue("R8 stall beq", mk_imm(6'h04, 16'h0010), 4, 4, 0, 1);
    issue("R8 stall regjump", mk_reg(6'h08), 0, 0, 32'hDEAD_BEE0, 1);
    issue("R8 stall seq", mk_imm(6'h09, 16'h0), 0, 0, 0, 1);
    issue("R6 call after stall", mk_far(6'h03, 26'h123), 0, 0, 0, 0);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    instr = mk_far(6'h03, 26'h7);
    #1;
    check("R1 link_we low in reset", {31'd0, link_we}, 32'd0);
    @(negedge clk);
    check("R1 reset reload", pc_q, START);
    rst = 1'b0;
    exp_pc = START;
    issue("R2 seq after reset", mk_imm(6'h0A, 16'h0), 0, 0, 0, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule